// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is the slave side of a chip-selected synchronous serial link for a converter-style peripheral. Every access opens with one 8-bit command. The command states whether the access reads or writes, how many bytes follow (1 to 4), which 24-bit internal register is involved, and which byte of that register comes first. The data phase then moves bytes between the link and that register.

Software can switch the bit order (MSB or LSB first) and the byte walk (descending or ascending) at run time through a control register. A separate serial output pin can be enabled; while it is disabled, read data goes back over the shared data line. The core loads conversion results through a strobe, and an active-low ready flag marks each new result until the result register is read.

The serial pins are oversampled by the block clock. The serial clock must therefore run several times slower than that clock.

Top module: `serial_reg_port`

## Requirements
- R1: While `cs_n` is low, the first 8 bits received form the command, and the data phase follows. Command bit 7 gives the direction: 0 reads, 1 writes.
- R2: Command bits 6:5 give the data-phase length in bytes: value plus one (1 to 4). After that many bytes, the port expects a new command.
- R3: Command bits 3:2 select the register: 0 is the result, 1 is control, 2 is offset, 3 is full-scale. For full-scale only, bit 4 selects the positive (0) or negative (1) copy. For the other registers, bit 4 has no effect.
- R4: Command bits 1:0 give the first byte index (0..2). In descending mode the index steps 2, 1, 0 and wraps from 0 to 2. In ascending mode it steps 0, 1, 2 and wraps from 2 to 0.
- R5: After reset, bits travel MSB first. When control bit 22 is 1, bits travel LSB first, for the command and for the data. A change to this bit applies from the next access on, never to the access that wrote it.
- R6: Control bit 23 set to 1 selects the ascending byte walk. Reset value is 0 (descending). Like bit 22, it applies from the next access on.
- R7: Input data is taken on the rising serial clock edge. Read data changes only after falling edges and holds steady while the serial clock is high.
- R8: `drdy_n` is 1 after reset and goes to 0 the clock after `res_load`. It returns to 1 only when a read access to the result register completes. Reads of other registers leave it unchanged.
- R9: Writes aimed at the result register leave its contents unchanged.
- R10: Control bit 21 enables `sdo`. When it is 0, read data is driven on `sdio_out` with `sdio_oe` high and `sdo_oe` low. When it is 1, read data is driven on `sdo` with `sdo_oe` high and `sdio_oe` low. Neither enable is high outside a read data phase.
- R11: Raising `cs_n` at any point ends the access. The next access starts with a fresh command.
- R12: After reset, all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdio_in | input | 1 | Receive side of the shared data line |
| sdio_out | output | 1 | Transmit side of the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Dedicated serial read-data output |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| res_load | input | 1 | Strobe that loads a new conversion result |
| res_value | input | 24 | Conversion result to load |
| drdy_n | output | 1 | Active-low result-ready flag |

## Verification
The bench walks the byte index past both ends of the register with a 4-byte access in each direction. A design that failed to wrap would read a non-existent fourth byte or stall. It switches to LSB-first/ascending with a single-byte write sent MSB first. A design that applied the new order within that same write would store a mirrored byte, and every later access would mismatch. Chip select is dropped halfway through a command. A port that kept its bit count would misread the next command as shifted bits. The bench also confirms three more cases: a write to the result register, which a faulty design would let corrupt the loaded value; reads of other registers, which must not clear the ready flag; and the two output enables, checked every clock so that both are never active at once.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned REG_BYTES = 3;
    localparam int unsigned REG_W     = BYTE_W * REG_BYTES;
    localparam int unsigned NUM_REGS  = 5;
    localparam logic [1:0]  LAST_IDX  = 2'(REG_BYTES - 1);

    typedef enum logic [2:0] {
        RS_DATA = 3'd0,
        RS_CTRL = 3'd1,
        RS_OFFS = 3'd2,
        RS_FSP  = 3'd3,
        RS_FSN  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    function automatic reg_sel_e decode_sel(input logic [1:0] fld, input logic fsc);
        case (fld)
            2'd0:    return RS_DATA;
            2'd1:    return RS_CTRL;
            2'd2:    return RS_OFFS;
            default: return fsc ? RS_FSN : RS_FSP;
        endcase
    endfunction

    function automatic logic [1:0] step_idx(input logic [1:0] idx, input logic asc);
        if (asc) return (idx >= LAST_IDX) ? 2'd0 : idx + 2'd1;
        return (idx == 2'd0) ? LAST_IDX : idx - 2'd1;
    endfunction
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic cs_act,
    output logic rise,
    output logic fall,
    output logic din
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] cs_sr;
        logic [STAGES-1:0] ck_sr;
        logic [STAGES-1:0] dt_sr;
        logic              ck_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.cs_sr   = {sync_q.cs_sr[STAGES-2:0], cs_n};
        sync_d.ck_sr   = {sync_q.ck_sr[STAGES-2:0], sclk};
        sync_d.dt_sr   = {sync_q.dt_sr[STAGES-2:0], sdio_in};
        sync_d.ck_prev = sync_q.ck_sr[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.cs_sr   <= '1;
            sync_q.ck_sr   <= '0;
            sync_q.dt_sr   <= '0;
            sync_q.ck_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cs_act = ~sync_q.cs_sr[LAST];
    assign rise   = sync_q.ck_sr[LAST] & ~sync_q.ck_prev;
    assign fall   = ~sync_q.ck_sr[LAST] & sync_q.ck_prev;
    assign din    = sync_q.dt_sr[LAST];
endmodule

// File: rtl/sport_engine.sv
module sport_engine
    import sport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_act,
    input  logic        rise,
    input  logic        fall,
    input  logic        din,
    input  logic        ctrl_lsb,
    input  logic        ctrl_asc,
    input  logic [7:0]  rd_byte,
    output reg_sel_e    rd_sel,
    output logic [1:0]  rd_idx,
    output logic        wr_stb,
    output reg_sel_e    wr_sel,
    output logic [1:0]  wr_idx,
    output logic [7:0]  wr_byte,
    output logic        rd_done,
    output logic        dout,
    output logic        oe
);
    typedef struct packed {
        phase_e     phase;
        logic [2:0] bitcnt;
        logic [7:0] sh;
        logic       dir_wr;
        logic [2:0] left;
        logic [1:0] idx;
        reg_sel_e   sel;
        logic       dout;
        logic       lsb_x;
        logic       asc_x;
        logic       wr_stb;
        logic [7:0] wr_byte;
        reg_sel_e   wr_sel;
        logic [1:0] wr_idx;
        logic       rd_done;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [7:0] nb;

    always_comb begin
        eng_d         = eng_q;
        eng_d.wr_stb  = 1'b0;
        eng_d.rd_done = 1'b0;
        nb = eng_q.lsb_x ? {din, eng_q.sh[7:1]} : {eng_q.sh[6:0], din};
        if (!cs_act) begin
            eng_d.phase  = PH_INSTR;
            eng_d.bitcnt = 3'd0;
            eng_d.lsb_x  = ctrl_lsb;
            eng_d.asc_x  = ctrl_asc;
        end else if (rise) begin
            eng_d.sh     = nb;
            eng_d.bitcnt = eng_q.bitcnt + 3'd1;
            if (eng_q.bitcnt == 3'd7) begin
                if (eng_q.phase == PH_INSTR) begin
                    eng_d.phase  = PH_DATA;
                    eng_d.dir_wr = nb[7];
                    eng_d.left   = {1'b0, nb[6:5]} + 3'd1;
                    eng_d.sel    = decode_sel(nb[3:2], nb[4]);
                    eng_d.idx    = (nb[1:0] > LAST_IDX) ? LAST_IDX : nb[1:0];
                end else begin
                    if (eng_q.dir_wr) begin
                        eng_d.wr_stb  = 1'b1;
                        eng_d.wr_byte = nb;
                        eng_d.wr_sel  = eng_q.sel;
                        eng_d.wr_idx  = eng_q.idx;
                    end
                    eng_d.idx  = step_idx(eng_q.idx, eng_q.asc_x);
                    eng_d.left = eng_q.left - 3'd1;
                    if (eng_q.left == 3'd1) begin
                        eng_d.phase   = PH_INSTR;
                        eng_d.rd_done = !eng_q.dir_wr && (eng_q.sel == RS_DATA);
                    end
                end
            end
        end else if (fall) begin
            if (eng_q.phase == PH_DATA && !eng_q.dir_wr)
                eng_d.dout = eng_q.lsb_x ? rd_byte[eng_q.bitcnt] : rd_byte[3'd7 - eng_q.bitcnt];
        end else if (eng_q.phase == PH_INSTR && eng_q.bitcnt == 3'd0) begin
            eng_d.lsb_x = ctrl_lsb;
            eng_d.asc_x = ctrl_asc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.sel   <= RS_DATA;
            eng_q.wr_sel <= RS_DATA;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rd_sel  = eng_q.sel;
    assign rd_idx  = eng_q.idx;
    assign wr_stb  = eng_q.wr_stb;
    assign wr_sel  = eng_q.wr_sel;
    assign wr_idx  = eng_q.wr_idx;
    assign wr_byte = eng_q.wr_byte;
    assign rd_done = eng_q.rd_done;
    assign dout    = eng_q.dout;
    assign oe      = cs_act && (eng_q.phase == PH_DATA) && !eng_q.dir_wr;

    // R11: a released select leaves the engine waiting for a command
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (eng_q.phase == PH_INSTR && eng_q.bitcnt == 3'd0));

    // R2: the data phase never runs with zero bytes left
    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.phase == PH_DATA |-> eng_q.left != 3'd0);

    // R7: read data holds while no falling edge is seen
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !fall && $past(cs_act)) |=> $stable(eng_q.dout));
endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int unsigned ASC_BIT = 23,
    parameter int unsigned LSB_BIT = 22,
    parameter int unsigned SDO_BIT = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_load,
    input  logic [REG_W-1:0] res_value,
    input  logic             wr_stb,
    input  reg_sel_e         wr_sel,
    input  logic [1:0]       wr_idx,
    input  logic [7:0]       wr_byte,
    input  reg_sel_e         rd_sel,
    input  logic [1:0]       rd_idx,
    input  logic             rd_done,
    output logic [7:0]       rd_byte,
    output logic             ctrl_asc,
    output logic             ctrl_lsb,
    output logic             ctrl_sdo,
    output logic             drdy_n
);
    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] r;
        logic                           drdy_n;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int s = 0; s < NUM_REGS; s++) begin
            for (int b = 0; b < REG_BYTES; b++) begin
                if (wr_stb && wr_sel != RS_DATA && int'(wr_sel) == s && wr_idx == 2'(b))
                    bank_d.r[s][b*BYTE_W +: BYTE_W] = wr_byte;
            end
        end
        if (rd_done) bank_d.drdy_n = 1'b1;
        if (res_load) begin
            bank_d.r[int'(RS_DATA)] = res_value;
            bank_d.drdy_n           = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.r      <= '0;
            bank_q.drdy_n <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int s = 0; s < NUM_REGS; s++)
            for (int b = 0; b < REG_BYTES; b++)
                if (int'(rd_sel) == s && rd_idx == 2'(b))
                    rd_byte = bank_q.r[s][b*BYTE_W +: BYTE_W];
    end

    assign ctrl_asc = bank_q.r[int'(RS_CTRL)][ASC_BIT];
    assign ctrl_lsb = bank_q.r[int'(RS_CTRL)][LSB_BIT];
    assign ctrl_sdo = bank_q.r[int'(RS_CTRL)][SDO_BIT];
    assign drdy_n   = bank_q.drdy_n;

    // R8: a load always raises the ready indication
    p_load_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |=> !drdy_n);

    // R9: writes to the result register do not alter it
    p_data_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == RS_DATA && !res_load) |=> $stable(bank_q.r[int'(RS_DATA)]));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ASC_BIT     = 23,
    parameter int unsigned LSB_BIT     = 22,
    parameter int unsigned SDO_BIT     = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdio_in,
    output logic        sdio_out,
    output logic        sdio_oe,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic        res_load,
    input  logic [23:0] res_value,
    output logic        drdy_n
);
    import sport_pkg::*;

    logic       cs_act, rise, fall, din;
    logic       ctrl_asc, ctrl_lsb, ctrl_sdo;
    logic [7:0] rd_byte, wr_byte;
    reg_sel_e   rd_sel, wr_sel;
    logic [1:0] rd_idx, wr_idx;
    logic       wr_stb, rd_done, dout, eng_oe;

    sport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .cs_act(cs_act), .rise(rise), .fall(fall), .din(din)
    );

    sport_engine u_engine (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise), .fall(fall),
        .din(din), .ctrl_lsb(ctrl_lsb), .ctrl_asc(ctrl_asc), .rd_byte(rd_byte),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_byte(wr_byte), .rd_done(rd_done), .dout(dout),
        .oe(eng_oe)
    );

    sport_regs #(.ASC_BIT(ASC_BIT), .LSB_BIT(LSB_BIT), .SDO_BIT(SDO_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .res_load(res_load), .res_value(res_value),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_done(rd_done), .rd_byte(rd_byte),
        .ctrl_asc(ctrl_asc), .ctrl_lsb(ctrl_lsb), .ctrl_sdo(ctrl_sdo),
        .drdy_n(drdy_n)
    );

    assign sdo      = dout;
    assign sdo_oe   = eng_oe & ctrl_sdo;
    assign sdio_out = dout;
    assign sdio_oe  = eng_oe & ~ctrl_sdo;

    // R10: only one data pin drives at a time
    p_oe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    // R10: the dedicated pin stays quiet while its enable bit is clear
    p_sdo_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_sdo |-> !sdo_oe);
endmodule

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, sdo, sdo_oe, drdy_n;
    logic        res_load = 1'b0;
    logic [23:0] res_value = '0;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    logic [23:0] m_reg [5];
    bit m_lsb = 0, m_asc = 0, m_sdo = 0, m_drdy = 1;

    always #2 clk = ~clk;

    serial_reg_port i_serial_reg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .res_load(res_load), .res_value(res_value), .drdy_n(drdy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // R10: per-clock comparison of the pin enables with the model
    always @(negedge clk) begin
        if (started && !done) begin
            if (sdio_oe && sdo_oe) check("R10 both enables", 1, 0);
            if (!m_sdo && sdo_oe)  check("R10 sdo while disabled", 1, 0);
        end
    end

    task automatic send_bit(input logic b);
        sdio_in = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic recv_bit(output logic b);
        logic late;
        repeat (4) @(negedge clk);
        b = m_sdo ? sdo : sdio_out;
        check("R10 read enable pins", {sdio_oe, sdo_oe}, m_sdo ? 32'd1 : 32'd2);
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        late = m_sdo ? sdo : sdio_out;
        check("R7 data stable while sclk high", late, b);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(m_lsb ? v[i] : v[7-i]);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic x;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(x);
            if (m_lsb) v[i] = x; else v[7-i] = x;
        end
    endtask

    task automatic xfer(input bit wr, input int cnt, input logic [1:0] fld, input bit fsc,
                        input logic [1:0] start, input logic [31:0] wdata, input string req);
        logic [7:0] ins, b;
        int tgt, idx;
        ins = {wr, 2'(cnt - 1), fsc, fld, start};
        tgt = (fld == 2'd3) ? (fsc ? 4 : 3) : int'(fld);
        idx = int'(start);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        send_byte(ins);
        for (int k = 0; k < cnt; k++) begin
            if (wr) begin
                b = wdata[k*8 +: 8];
                send_byte(b);
                if (tgt != 0) m_reg[tgt][idx*8 +: 8] = b;
            end else begin
                recv_byte(b);
                check(req, {24'd0, b}, {24'd0, m_reg[tgt][idx*8 +: 8]});
            end
            idx = m_asc ? ((idx == 2) ? 0 : idx + 1) : ((idx == 0) ? 2 : idx - 1);
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        if (!wr && tgt == 0) m_drdy = 1;
        m_asc = m_reg[1][23];
        m_lsb = m_reg[1][22];
        m_sdo = m_reg[1][21];
    endtask

    task automatic load(input logic [23:0] v);
        @(negedge clk);
        res_value = v;
        res_load = 1'b1;
        @(negedge clk);
        res_load = 1'b0;
        m_reg[0] = v;
        m_drdy = 0;
    endtask

    initial begin
        for (int i = 0; i < 5; i++) m_reg[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        started = 1;

        check("R12 reset drdy_n", drdy_n, 1);
        check("R12 reset enables", {sdio_oe, sdo_oe}, 0);
        xfer(0, 3, 2'd2, 0, 2'd2, 0, "R12 offset reads zero");

        load(24'hA5C33C);
        check("R8 drdy low after load", drdy_n, 0);

        xfer(1, 3, 2'd2, 0, 2'd2, 32'h00332211, "R1 write offset");
        xfer(0, 3, 2'd2, 0, 2'd2, 0, "R1 R4 read offset descending");

        xfer(1, 3, 2'd3, 0, 2'd2, 32'h00C0FFEE, "R3 write positive full-scale");
        xfer(1, 3, 2'd3, 1, 2'd2, 32'h00123456, "R3 write negative full-scale");
        xfer(0, 3, 2'd3, 0, 2'd2, 0, "R3 read positive full-scale");
        xfer(0, 3, 2'd3, 1, 2'd2, 0, "R3 read negative full-scale");
        xfer(0, 3, 2'd2, 1, 2'd2, 0, "R3 bit4 ignored for offset");

        xfer(0, 4, 2'd2, 0, 2'd0, 0, "R4 R2 four bytes wrap descending");
        xfer(0, 1, 2'd2, 0, 2'd1, 0, "R2 single byte");
        xfer(0, 2, 2'd2, 0, 2'd1, 0, "R2 two bytes");
        check("R8 drdy held by other reads", drdy_n, 0);

        xfer(1, 3, 2'd0, 0, 2'd2, 32'h00777777, "R9 write result register");
        xfer(0, 3, 2'd0, 0, 2'd2, 0, "R9 result unchanged");
        check("R8 drdy high after result read", drdy_n, 1);

        load(24'h0F1E2D);
        xfer(0, 1, 2'd1, 0, 2'd2, 0, "R8 read control");
        check("R8 control read keeps drdy low", drdy_n, 0);

        // R11: abort half-way through a command
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R11 idle after abort", {sdio_oe, sdo_oe}, 0);
        xfer(0, 2, 2'd2, 0, 2'd2, 0, "R11 clean access after abort");

        // R5 R6: ascending + LSB first, written while still MSB first
        xfer(1, 1, 2'd1, 0, 2'd2, 32'h000000C0, "R5 R6 set order");
        check("R5 model now LSB first", m_lsb, 1);
        xfer(0, 3, 2'd1, 0, 2'd0, 0, "R5 R6 control readback");
        xfer(0, 3, 2'd2, 0, 2'd0, 0, "R6 R5 offset ascending LSB first");
        xfer(0, 4, 2'd3, 1, 2'd1, 0, "R6 R4 ascending wrap");

        // R10: enable the dedicated output
        xfer(1, 1, 2'd1, 0, 2'd2, 32'h000000E0, "R10 enable sdo");
        xfer(0, 3, 2'd2, 0, 2'd0, 0, "R10 offset over sdo");
        xfer(0, 3, 2'd0, 0, 2'd0, 0, "R10 R8 result over sdo");
        check("R8 drdy high after sdo read", drdy_n, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule